// File: doc/BRIEF.md
# Overlapping Audio Frame Buffer

This block takes a continuous stream of 16-bit audio samples, one per valid strobe, and keeps them in a circular store. Samples are counted in segments of a fixed number of samples. Once a full frame of segments has been captured since reset, the block announces a new frame every time a programmable number of further segments has arrived. Successive frames therefore overlap, and the amount of new audio between them is always a whole number of segments.

A downstream consumer reacts to the frame-ready pulse. It reads the announced frame through an offset-addressed read port: offset 0 is the oldest sample of the frame and the highest offset is the newest. The block turns each offset into a physical location in the ring relative to a start pointer that it latches when the frame is announced, so no data is ever moved. The store holds one frame plus the largest shift. Incoming audio therefore never overwrites a frame before the next one is announced. The consumer acknowledges each frame, and an overrun pulse marks a frame announced while the previous one was still unacknowledged.

The defaults are 16 samples per segment, an 8-segment frame and a shift of at most 4 segments. A full-size instance sets the frame to 1024 segments and allows a shift of 40 segments, which is 40 ms of audio at 16 kHz.

Top module: `overlap_frame_buf`

## Requirements
- R1: A sample is stored at each rising clock edge where sample_valid_i is high. An edge with sample_valid_i low stores nothing and advances no pointer or counter, whatever the value on sample_i.
- R2: After reset, the first frame_ready_o pulse is high in the cycle following the edge that stores the FRAME_SEGS*SEG_LEN-th sample. No pulse occurs before that.
- R3: After the first frame, frame_ready_o pulses once for every shift*SEG_LEN further stored samples, in the cycle after the edge that stores the last sample of the segment that completes the shift. Each pulse lasts one cycle.
- R4: The effective shift is shift_segs_i, read each time a segment completes. A value of 0 acts as 1, and a value above MAX_SHIFT_SEGS acts as MAX_SHIFT_SEGS.
- R5: One cycle after offset k is presented on rd_addr_i, rd_data_o holds sample number (N - FRAME_LEN + k). Here N is the count of samples stored when the current frame was announced, and samples are numbered from 0. Offset 0 is the oldest sample of the frame and offset FRAME_LEN-1 is the newest.
- R6: The contents read for the current frame do not change while further samples are stored, up to the announcement of the next frame.
- R7: overrun_o pulses together with frame_ready_o when a frame is announced and the previous frame has had no frame_ack_i high at any clock edge since it was announced. A frame that has been acknowledged gives no overrun on the next announcement.
- R8: When rst_ni is low, all pointers, counters and the pending-frame state are cleared, and frame_ready_o, overrun_o and rd_data_o are 0. After reset is released, a full frame must be captured again before the next announcement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Store sample_i at this edge |
| sample_i | input | SAMPLE_W | Audio sample |
| shift_segs_i | input | $clog2(MAX_SHIFT_SEGS+1) | Segments of new audio between frames |
| frame_ready_o | output | 1 | One-cycle pulse: a new frame can be read |
| frame_ack_i | input | 1 | Consumer has finished with the current frame |
| overrun_o | output | 1 | One-cycle pulse: a frame was announced before the previous one was acknowledged |
| rd_addr_i | input | $clog2(SEG_LEN*FRAME_SEGS) | Sample offset within the current frame, 0 = oldest |
| rd_data_o | output | SAMPLE_W | Sample at the requested offset, one cycle later |

## Verification
frame_ready_o and overrun_o are registered, so they become visible in the cycle after the edge that stores the last sample of the completing segment. rd_data_o is visible one cycle after the edge that samples rd_addr_i. The bench drives each input on a falling edge and samples results 1 ns after the following rising edge, so each push or read observes exactly the edge it caused. Frame-interval checks count the samples pushed between pulses, and idle cycles are inserted so that gaps in sample_valid_i cannot shift that count. Expected read data comes from a running sample index, not from the ring pointers.

// File: rtl/afb_pkg.sv
package afb_pkg;
  typedef enum logic [0:0] {
    FILLING   = 1'b0,
    STREAMING = 1'b1
  } fill_state_e;
endpackage

// File: rtl/afb_wr_ctrl.sv
module afb_wr_ctrl #(
  parameter int SEG_LEN = 16,
  parameter int DEPTH   = 192,
  localparam int SCW    = $clog2(SEG_LEN),
  localparam int PW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] wr_ptr_next_o,
  output logic          seg_done_o
);
  logic [SCW-1:0] samp_cnt_q;
  logic [PW-1:0]  wr_ptr_q;
  logic [PW-1:0]  wr_ptr_inc;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_ptr_inc = wr_ptr_q + PW'(1);
    end else begin : g_wrap
      assign wr_ptr_inc = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + PW'(1);
    end
  endgenerate

  assign seg_done_o    = valid_i && (samp_cnt_q == SCW'(SEG_LEN - 1));
  assign wr_ptr_o      = wr_ptr_q;
  assign wr_ptr_next_o = wr_ptr_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_cnt_q <= '0;
      wr_ptr_q   <= '0;
    end else if (valid_i) begin
      samp_cnt_q <= seg_done_o ? '0 : samp_cnt_q + SCW'(1);
      wr_ptr_q   <= wr_ptr_inc;
    end
  end
endmodule

// File: rtl/afb_frame_sched.sv
module afb_frame_sched
  import afb_pkg::*;
#(
  parameter int FRAME_SEGS     = 8,
  parameter int MAX_SHIFT_SEGS = 4,
  parameter int FRAME_LEN      = 128,
  parameter int DEPTH          = 192,
  localparam int PW            = $clog2(DEPTH),
  localparam int SHW           = $clog2(MAX_SHIFT_SEGS + 1),
  localparam int FCW           = $clog2(FRAME_SEGS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           seg_done_i,
  input  logic [PW-1:0]  wr_ptr_next_i,
  input  logic [SHW-1:0] shift_segs_i,
  input  logic           ack_i,
  output logic           frame_ready_o,
  output logic           overrun_o,
  output logic [PW-1:0]  start_o
);
  fill_state_e    state_q;
  logic [FCW-1:0] fill_cnt_q;
  logic [SHW-1:0] shift_cnt_q;
  logic [SHW-1:0] shift_eff;
  logic           shift_hit;
  logic           fill_hit;
  logic           fire;
  logic           pending_q;
  logic [PW-1:0]  start_q;
  logic [PW:0]    start_sum;
  logic [PW-1:0]  start_nxt;

  always_comb begin
    if (shift_segs_i == '0)                            shift_eff = SHW'(1);
    else if (shift_segs_i > SHW'(MAX_SHIFT_SEGS))      shift_eff = SHW'(MAX_SHIFT_SEGS);
    else                                               shift_eff = shift_segs_i;
  end

  assign shift_hit = ({1'b0, shift_cnt_q} + (SHW+1)'(1)) >= {1'b0, shift_eff};
  assign fill_hit  = fill_cnt_q == FCW'(FRAME_SEGS - 1);
  assign fire      = seg_done_i && ((state_q == FILLING) ? fill_hit : shift_hit);

  // oldest sample of the frame that ends just before wr_ptr_next_i
  assign start_sum = {1'b0, wr_ptr_next_i} + (PW+1)'(DEPTH - FRAME_LEN);
  assign start_nxt = (start_sum >= (PW+1)'(DEPTH)) ? PW'(start_sum - (PW+1)'(DEPTH))
                                                   : PW'(start_sum);
  assign start_o   = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= FILLING;
      fill_cnt_q    <= '0;
      shift_cnt_q   <= '0;
      pending_q     <= 1'b0;
      start_q       <= '0;
      frame_ready_o <= 1'b0;
      overrun_o     <= 1'b0;
    end else begin
      if (seg_done_i) begin
        if (state_q == FILLING) begin
          fill_cnt_q <= fill_cnt_q + FCW'(1);
          if (fill_hit) state_q <= STREAMING;
        end else begin
          shift_cnt_q <= shift_hit ? '0 : shift_cnt_q + SHW'(1);
        end
      end
      if (fire) start_q <= start_nxt;
      pending_q     <= fire | (pending_q & ~ack_i);
      frame_ready_o <= fire;
      overrun_o     <= fire & pending_q & ~ack_i;
    end
  end
endmodule

// File: rtl/afb_rd_xlate.sv
module afb_rd_xlate #(
  parameter int DEPTH = 192,
  parameter int FAW   = 7,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [PW-1:0]  start_i,
  input  logic [FAW-1:0] off_i,
  output logic [PW-1:0]  phys_o
);
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign phys_o = start_i + PW'(off_i);
    end else begin : g_wrap
      logic [PW:0] sum;
      assign sum    = {1'b0, start_i} + (PW+1)'(off_i);
      assign phys_o = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : PW'(sum);
    end
  endgenerate
endmodule

// File: rtl/afb_ring_store.sv
module afb_ring_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 192,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/overlap_frame_buf.sv
module overlap_frame_buf #(
  parameter int SAMPLE_W       = 16,
  parameter int SEG_LEN        = 16,
  parameter int FRAME_SEGS     = 8,
  parameter int MAX_SHIFT_SEGS = 4,
  localparam int FRAME_LEN     = SEG_LEN * FRAME_SEGS,
  localparam int DEPTH         = SEG_LEN * (FRAME_SEGS + MAX_SHIFT_SEGS),
  localparam int PW            = $clog2(DEPTH),
  localparam int FAW           = $clog2(FRAME_LEN),
  localparam int SHW           = $clog2(MAX_SHIFT_SEGS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SHW-1:0]      shift_segs_i,
  output logic                frame_ready_o,
  input  logic                frame_ack_i,
  output logic                overrun_o,
  input  logic [FAW-1:0]      rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o
);
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] wr_ptr_next;
  logic          seg_done;
  logic [PW-1:0] start_ptr;
  logic [PW-1:0] rd_phys;

  afb_wr_ctrl #(.SEG_LEN(SEG_LEN), .DEPTH(DEPTH)) u_wr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (sample_valid_i),
    .wr_ptr_o      (wr_ptr),
    .wr_ptr_next_o (wr_ptr_next),
    .seg_done_o    (seg_done)
  );

  afb_frame_sched #(
    .FRAME_SEGS     (FRAME_SEGS),
    .MAX_SHIFT_SEGS (MAX_SHIFT_SEGS),
    .FRAME_LEN      (FRAME_LEN),
    .DEPTH          (DEPTH)
  ) u_sched (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .seg_done_i    (seg_done),
    .wr_ptr_next_i (wr_ptr_next),
    .shift_segs_i  (shift_segs_i),
    .ack_i         (frame_ack_i),
    .frame_ready_o (frame_ready_o),
    .overrun_o     (overrun_o),
    .start_o       (start_ptr)
  );

  afb_rd_xlate #(.DEPTH(DEPTH), .FAW(FAW)) u_xlate (
    .start_i (start_ptr),
    .off_i   (rd_addr_i),
    .phys_o  (rd_phys)
  );

  afb_ring_store #(.DW(SAMPLE_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sample_valid_i),
    .waddr_i (wr_ptr),
    .wdata_i (sample_i),
    .raddr_i (rd_phys),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/afb_checker.sv
module afb_checker #(
  parameter int FRAME_LEN = 128,
  localparam int CW       = $clog2(FRAME_LEN + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_valid_i,
  input logic frame_ready_o,
  input logic overrun_o
);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          seen_q <= '0;
    else if (sample_valid_i && seen_q != CW'(FRAME_LEN))  seen_q <= seen_q + CW'(1);
  end

  // R2: no frame before a full frame of samples since reset
  p_no_early_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |-> seen_q == CW'(FRAME_LEN));

  // R3: announcement is a single-cycle pulse
  p_ready_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> !frame_ready_o);

  // R1: a frame can only follow a stored sample
  p_ready_after_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |-> $past(sample_valid_i));

  // R7: overrun only accompanies an announcement
  p_overrun_with_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> frame_ready_o);
endmodule

bind overlap_frame_buf afb_checker #(.FRAME_LEN(SEG_LEN * FRAME_SEGS)) u_afb_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .frame_ready_o  (frame_ready_o),
  .overrun_o      (overrun_o)
);

// File: tb/overlap_frame_buf_test.sv
`timescale 1ns/1ps
module overlap_frame_buf_test;
  localparam int SW        = 16;
  localparam int SEG_LEN   = 16;
  localparam int FSEGS     = 8;
  localparam int MAXSH     = 4;
  localparam int FRAME_LEN = SEG_LEN * FSEGS;
  localparam int FAW       = $clog2(FRAME_LEN);
  localparam int SHW       = $clog2(MAXSH + 1);
  localparam int NV        = 6;

  // shift request, idle cycles between samples, expected samples per frame, read offset
  localparam int VSHIFT [NV] = '{4, 1, 2, 0, 7, 3};
  localparam int VGAP   [NV] = '{0, 1, 2, 0, 3, 0};
  localparam int VEXP   [NV] = '{64, 16, 32, 16, 64, 48};
  localparam int VK     [NV] = '{0, 127, 50, 1, 100, 64};

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           sample_valid = 1'b0;
  logic [SW-1:0]  sample = '0;
  logic [SHW-1:0] shift_segs = SHW'(4);
  logic           frame_ready;
  logic           frame_ack = 1'b0;
  logic           overrun;
  logic [FAW-1:0] rd_addr = '0;
  logic [SW-1:0]  rd_data;

  int n_chk = 0, n_fail = 0;
  int seq = 0, since_fire = 0, last_gap = 0, frame_end = 0;
  bit fired = 0, ovr_seen = 0;

  always #5 clk = ~clk;

  overlap_frame_buf #(.SAMPLE_W(SW), .SEG_LEN(SEG_LEN), .FRAME_SEGS(FSEGS),
                      .MAX_SHIFT_SEGS(MAXSH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sample_valid), .sample_i(sample),
    .shift_segs_i(shift_segs), .frame_ready_o(frame_ready), .frame_ack_i(frame_ack),
    .overrun_o(overrun), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  function automatic logic [SW-1:0] fv(int n);
    return SW'(n * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push();
    @(negedge clk);
    sample_valid = 1'b1;
    sample = fv(seq);
    @(posedge clk);
    #1;
    sample_valid = 1'b0;
    seq++;
    since_fire++;
    fired = frame_ready;
    ovr_seen = overrun;
    if (fired) begin
      last_gap = since_fire;
      since_fire = 0;
      frame_end = seq;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample = 16'hBEEF ^ SW'(i);
    end
  endtask

  task automatic run_to_frame(int gap);
    fired = 0;
    for (int g = 0; g < 400 && !fired; g++) begin
      push();
      if (!fired) idle(gap);
    end
  endtask

  task automatic read_chk(int k, string req);
    logic [SW-1:0] exp;
    exp = fv(frame_end - FRAME_LEN + k);
    @(negedge clk);
    rd_addr = FAW'(k);
    @(posedge clk);
    #1;
    chk(rd_data == exp, req, int'(rd_data), int'(exp));
  endtask

  task automatic ack();
    @(negedge clk);
    frame_ack = 1'b1;
    @(posedge clk);
    #1;
    frame_ack = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(frame_ready == 1'b0, "R8 ready in reset", int'(frame_ready), 0);
    chk(overrun == 1'b0, "R8 overrun in reset", int'(overrun), 0);
    chk(rd_data == '0, "R8 rdata in reset", int'(rd_data), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // first frame
    run_to_frame(0);
    chk(fired && last_gap == FRAME_LEN, "R2 first frame", last_gap, FRAME_LEN);
    chk(ovr_seen == 1'b0, "R7 no overrun first", int'(ovr_seen), 0);
    read_chk(0, "R5 oldest");
    read_chk(FRAME_LEN - 1, "R5 newest");
    ack();

    // vector walk: shift values, idle gaps, read offsets
    for (int v = 0; v < NV; v++) begin
      shift_segs = SHW'(VSHIFT[v]);
      run_to_frame(VGAP[v]);
      chk(fired && last_gap == VEXP[v], "R3/R4 frame interval", last_gap, VEXP[v]);
      chk(ovr_seen == 1'b0, "R7 acked no overrun", int'(ovr_seen), 0);
      read_chk(VK[v], "R5 offset read");
      ack();
      for (int j = 0; j < 8; j++) push();
      chk(!fired, "R3 no pulse mid-segment", int'(fired), 0);
      read_chk(VK[v], "R6 stable under writes");
    end

    // R1: idle cycles with changing data do not advance anything
    shift_segs = SHW'(1);
    run_to_frame(0);
    ack();
    for (int j = 0; j < 5; j++) push();
    idle(20);
    run_to_frame(0);
    chk(fired && last_gap == SEG_LEN, "R1 idle ignored", last_gap, SEG_LEN);
    read_chk(FRAME_LEN - 1, "R1 newest after idle");
    ack();

    // R7: unacknowledged frame followed by another
    shift_segs = SHW'(2);
    run_to_frame(0);
    chk(ovr_seen == 1'b0, "R7 acked frame", int'(ovr_seen), 0);
    run_to_frame(0);
    chk(fired && ovr_seen == 1'b1, "R7 overrun", int'(ovr_seen), 1);
    chk(last_gap == 2 * SEG_LEN, "R3 interval with overrun", last_gap, 2 * SEG_LEN);
    read_chk(3, "R5 read after overrun");
    ack();

    // R8: reset mid-stream, full frame needed again
    for (int j = 0; j < 10; j++) push();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(frame_ready == 1'b0 && overrun == 1'b0, "R8 outputs in reset",
        int'({frame_ready, overrun}), 0);
    chk(rd_data == '0, "R8 rdata cleared", int'(rd_data), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    since_fire = 0;
    run_to_frame(0);
    chk(fired && last_gap == FRAME_LEN, "R8 refill after reset", last_gap, FRAME_LEN);
    read_chk(0, "R8 oldest after reset");
    read_chk(FRAME_LEN - 1, "R8 newest after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule